// File: doc/BRIEF.md
# Translation Fault Syndrome Unit

This unit sits behind an address translation stage and turns a failed lookup into something an exception handler can act on. When the translator raises its fault strobe, the unit looks at the outcome code, the kind of access that faulted and whether it was a write. From these it picks one of six exception classes and builds a 32-bit error code. The class and code are registered and appear one cycle after the strobe. The class then stays raised until the consumer acknowledges it.

Data-side faults also update two status registers: one holds the faulting address and one holds the error code. Software reads either register through a small select-driven read port. Instruction-fetch faults never change the status registers. Delivering the exception and flushing the pipeline are left to other blocks.

Top module: `fault_syndrome_unit`

## Requirements
- R1: While reset is asserted and right after it, `excClass` is 0 (none), and `errCode`, `addrReg` and `syndReg` are all zero.
- R2: A fault strobe is captured on the rising edge where it is sampled high, and the result shows from that edge on. `excClass` then holds until `ack` is sampled high, which clears it to 0 and leaves `errCode` unchanged. When the strobe and `ack` arrive together, the new fault wins.
- R3: Access type 0 is an instruction fetch, and its faults give class 1 (instruction storage). The error code is 0x40000000 for outcome 1 (no entry), 0x08000000 for outcome 2 (violation), and 0x10000000 for outcome 3 (no-execute) or outcome 4 (direct-store error).
- R4: Any nonzero access type is data side. Its faults give class 2 (data storage), with 0x40000000 for outcome 1, 0x08000000 for outcome 2, and a base code of 0 for outcome 3.
- R5: A data-side direct-store error (outcome 4) is handled by access type. Access type 2 (float) gives class 5 (alignment) with code 0x00000010. Access type 3 (reservation) gives class 2 with 0x04000000. Access type 4 (external control) gives class 2 with 0x04100000.
- R6: A data-side direct-store error on access type 1, 5, 6 or 7 gives class 6 (program check) with the invalid-operation code 0x00000020.
- R7: Outcome 5 (no segment match) gives class 3 on the instruction side and class 4 on the data side, always with error code 0.
- R8: Bit 25 (0x02000000) is ORed into the error code only when the final class is 2 and `isWrite` is 1. Alignment, program and segment classes never carry it.
- R9: A captured data-side fault loads `addrReg` with `faultAddr` and `syndReg` with the new error code. An instruction-side fault leaves both registers unchanged.
- R10: A strobe whose outcome is 0, 6 or 7 is ignored, and all four outputs keep their values.
- R11: `rdData` shows `addrReg` when `rdSel` is 0 and `syndReg` when `rdSel` is 1, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | 1 | Fault strobe from the translator |
| outcome | input | 3 | Lookup outcome code |
| accType | input | 3 | Access type of the faulting access |
| isWrite | input | 1 | 1 when the faulting access was a write |
| faultAddr | input | ADDR_W | Faulting effective address |
| ack | input | 1 | Clears the raised exception class |
| rdSel | input | 1 | Read port select: 0 address, 1 syndrome |
| excClass | output | 3 | Raised exception class |
| errCode | output | 32 | Error code of the last captured fault |
| addrReg | output | ADDR_W | Data-side fault address register |
| syndReg | output | 32 | Data-side syndrome register |
| rdData | output | ADDR_W | Software read data |

## Verification
The assertions assume the control inputs are never unknown after reset. They also assume `faultAddr` is stable on the edge where a strobe is sampled, because the latch check compares the register against the address from that edge. The bench drives every input on the falling clock edge and holds it across the next rising edge, so each sampled value is well defined. The stimulus covers every outcome code 0 to 7 and every access type 0 to 7, plus a random stretch with fault and acknowledge overlapping. Every cycle's outputs are compared against a behavioural model.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int CODE_W = 32;

  localparam logic [2:0] EXC_NONE  = 3'd0;
  localparam logic [2:0] EXC_ISI   = 3'd1;
  localparam logic [2:0] EXC_DSI   = 3'd2;
  localparam logic [2:0] EXC_ISEG  = 3'd3;
  localparam logic [2:0] EXC_DSEG  = 3'd4;
  localparam logic [2:0] EXC_ALIGN = 3'd5;
  localparam logic [2:0] EXC_PROG  = 3'd6;

  localparam logic [2:0] RES_NO_ENTRY  = 3'd1;
  localparam logic [2:0] RES_VIOLATION = 3'd2;
  localparam logic [2:0] RES_NO_EXEC   = 3'd3;
  localparam logic [2:0] RES_DIRECT    = 3'd4;
  localparam logic [2:0] RES_NO_SEG    = 3'd5;

  localparam logic [2:0] ACC_FETCH = 3'd0;
  localparam logic [2:0] ACC_FLOAT = 3'd2;
  localparam logic [2:0] ACC_RESV  = 3'd3;
  localparam logic [2:0] ACC_EXTC  = 3'd4;

  localparam logic [CODE_W-1:0] CODE_NO_ENTRY = 32'h4000_0000;
  localparam logic [CODE_W-1:0] CODE_VIOL     = 32'h0800_0000;
  localparam logic [CODE_W-1:0] CODE_NX       = 32'h1000_0000;
  localparam logic [CODE_W-1:0] CODE_RESV     = 32'h0400_0000;
  localparam logic [CODE_W-1:0] CODE_EXTC     = 32'h0410_0000;
  localparam logic [CODE_W-1:0] CODE_STORE    = 32'h0200_0000;
  localparam logic [CODE_W-1:0] CODE_ALIGN    = 32'h0000_0010;
  localparam logic [CODE_W-1:0] CODE_INVALID  = 32'h0000_0020;

  typedef struct packed {
    logic              capture;
    logic              clearClass;
    logic              latchStatus;
    logic [2:0]        cls;
    logic [CODE_W-1:0] code;
  } fsuStrobe_t;
endpackage

// File: rtl/fsu_ctrl.sv
module fsu_ctrl
  import fsu_pkg::*;
(
  input  logic       faultValid,
  input  logic [2:0] outcome,
  input  logic [2:0] accType,
  input  logic       isWrite,
  input  logic       ack,
  output fsuStrobe_t st
);
  logic              fetchSide;
  logic              knownOutcome;
  logic [2:0]        cls;
  logic [CODE_W-1:0] baseCode;

  assign fetchSide    = (accType == ACC_FETCH);
  assign knownOutcome = (outcome >= RES_NO_ENTRY) && (outcome <= RES_NO_SEG);

  always_comb begin
    cls      = EXC_NONE;
    baseCode = '0;
    case (outcome)
      RES_NO_ENTRY: begin
        cls      = fetchSide ? EXC_ISI : EXC_DSI;
        baseCode = CODE_NO_ENTRY;
      end
      RES_VIOLATION: begin
        cls      = fetchSide ? EXC_ISI : EXC_DSI;
        baseCode = CODE_VIOL;
      end
      RES_NO_EXEC: begin
        cls      = fetchSide ? EXC_ISI : EXC_DSI;
        baseCode = fetchSide ? CODE_NX : '0;
      end
      RES_DIRECT: begin
        if (fetchSide) begin
          cls      = EXC_ISI;
          baseCode = CODE_NX;
        end else begin
          case (accType)
            ACC_FLOAT: begin cls = EXC_ALIGN; baseCode = CODE_ALIGN;   end
            ACC_RESV:  begin cls = EXC_DSI;   baseCode = CODE_RESV;    end
            ACC_EXTC:  begin cls = EXC_DSI;   baseCode = CODE_EXTC;    end
            default:   begin cls = EXC_PROG;  baseCode = CODE_INVALID; end
          endcase
        end
      end
      RES_NO_SEG: begin
        cls      = fetchSide ? EXC_ISEG : EXC_DSEG;
        baseCode = '0;
      end
      default: begin
        cls      = EXC_NONE;
        baseCode = '0;
      end
    endcase
  end

  always_comb begin
    st.capture     = faultValid && knownOutcome;
    st.clearClass  = ack;
    st.latchStatus = faultValid && knownOutcome && !fetchSide;
    st.cls         = cls;
    st.code        = (cls == EXC_DSI && isWrite) ? (baseCode | CODE_STORE) : baseCode;
  end
endmodule

// File: rtl/fsu_dp.sv
module fsu_dp
  import fsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsuStrobe_t        st,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              rdSel,
  output logic [2:0]        excClass,
  output logic [CODE_W-1:0] errCode,
  output logic [ADDR_W-1:0] addrReg,
  output logic [CODE_W-1:0] syndReg,
  output logic [ADDR_W-1:0] rdData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      excClass <= EXC_NONE;
      errCode  <= '0;
    end else if (st.capture) begin
      excClass <= st.cls;
      errCode  <= st.code;
    end else if (st.clearClass) begin
      excClass <= EXC_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      syndReg <= '0;
    end else if (st.latchStatus) begin
      addrReg <= faultAddr;
      syndReg <= st.code;
    end
  end

  assign rdData = rdSel ? ADDR_W'(syndReg) : addrReg;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    st.clearClass && !st.capture |=> excClass == EXC_NONE); // R2
  AST_SEG_CODE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (excClass == EXC_ISEG || excClass == EXC_DSEG) |-> errCode == '0); // R7
  AST_NO_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.capture |=> $stable(errCode)); // R10
  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    excClass <= EXC_PROG); // R2
endmodule

// File: rtl/fault_syndrome_unit.sv
module fault_syndrome_unit
  import fsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic [2:0]        outcome,
  input  logic [2:0]        accType,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              ack,
  input  logic              rdSel,
  output logic [2:0]        excClass,
  output logic [31:0]       errCode,
  output logic [ADDR_W-1:0] addrReg,
  output logic [31:0]       syndReg,
  output logic [ADDR_W-1:0] rdData
);
  fsuStrobe_t st;

  fsu_ctrl u_ctrl (
    .faultValid (faultValid),
    .outcome    (outcome),
    .accType    (accType),
    .isWrite    (isWrite),
    .ack        (ack),
    .st         (st)
  );

  fsu_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .faultAddr (faultAddr),
    .rdSel     (rdSel),
    .excClass  (excClass),
    .errCode   (errCode),
    .addrReg   (addrReg),
    .syndReg   (syndReg),
    .rdData    (rdData)
  );

  AST_STORE_BIT_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && outcome >= 3'd1 && outcome <= 3'd5 && !isWrite |=> !errCode[25]); // R8
  AST_FETCH_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && accType == 3'd0 |=> $stable(addrReg) && $stable(syndReg)); // R9
  AST_DATA_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && outcome >= 3'd1 && outcome <= 3'd5 && accType != 3'd0
    |=> addrReg == $past(faultAddr) && syndReg == errCode); // R9
endmodule

// File: tb/sim_fault_syndrome_unit.sv
`timescale 1ns/1ps
module sim_fault_syndrome_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultValid = 1'b0;
  logic [2:0]  outcome = '0;
  logic [2:0]  accType = '0;
  logic        isWrite = 1'b0;
  logic [31:0] faultAddr = '0;
  logic        ack = 1'b0;
  logic        rdSel = 1'b0;
  logic [2:0]  excClass;
  logic [31:0] errCode;
  logic [31:0] addrReg;
  logic [31:0] syndReg;
  logic [31:0] rdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int unsigned mClass = 0;
  logic [31:0] mCode = '0;
  logic [31:0] mAddr = '0;
  logic [31:0] mSynd = '0;

  always #4 clk = ~clk;

  fault_syndrome_unit #(.ADDR_W(32)) u0 (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .outcome(outcome),
    .accType(accType), .isWrite(isWrite), .faultAddr(faultAddr), .ack(ack),
    .rdSel(rdSel), .excClass(excClass), .errCode(errCode), .addrReg(addrReg),
    .syndReg(syndReg), .rdData(rdData)
  );

  // Behavioural reference: side first, then outcome, then access kind.
  task automatic refDecode(input int oc, input int acc, input bit wr,
                           output int cls, output logic [31:0] code);
    cls  = 0;
    code = 32'h0;
    if (acc == 0) begin
      if (oc == 1)      begin cls = 1; code = 32'h4000_0000; end
      else if (oc == 2) begin cls = 1; code = 32'h0800_0000; end
      else if (oc == 3 || oc == 4) begin cls = 1; code = 32'h1000_0000; end
      else if (oc == 5) begin cls = 3; code = 32'h0; end
    end else begin
      if (oc == 1)      begin cls = 2; code = 32'h4000_0000; end
      else if (oc == 2) begin cls = 2; code = 32'h0800_0000; end
      else if (oc == 3) begin cls = 2; code = 32'h0; end
      else if (oc == 5) begin cls = 4; code = 32'h0; end
      else if (oc == 4) begin
        if (acc == 2)      begin cls = 5; code = 32'h0000_0010; end
        else if (acc == 3) begin cls = 2; code = 32'h0400_0000; end
        else if (acc == 4) begin cls = 2; code = 32'h0410_0000; end
        else               begin cls = 6; code = 32'h0000_0020; end
      end
    end
    if (cls == 2 && wr) code = code + 32'h0200_0000;
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    cmp(tag, "excClass", {29'd0, excClass}, mClass[31:0]);
    cmp(tag, "errCode", errCode, mCode);
    cmp(tag, "addrReg", addrReg, mAddr);
    cmp(tag, "syndReg", syndReg, mSynd);
    cmp(tag, "rdData", rdData, rdSel ? mSynd : mAddr);
  endtask

  task automatic step(input string tag, input bit fv, input int oc, input int acc,
                      input bit wr, input logic [31:0] addr, input bit ak, input bit sel);
    int c;
    logic [31:0] k;
    faultValid = fv;
    outcome    = oc[2:0];
    accType    = acc[2:0];
    isWrite    = wr;
    faultAddr  = addr;
    ack        = ak;
    rdSel      = sel;
    @(posedge clk);
    refDecode(oc, acc, wr, c, k);
    if (fv && oc >= 1 && oc <= 5) begin
      mClass = c;
      mCode  = k;
      if (acc != 0) begin
        mAddr = addr;
        mSynd = k;
      end
    end else if (ak) begin
      mClass = 0;
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle(input string tag, input bit sel);
    step(tag, 1'b0, 0, 0, 1'b0, 32'h0, 1'b0, sel);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R3: instruction side, status registers untouched (R9)
    step("R3", 1, 1, 0, 0, 32'h1111_0000, 0, 0);
    step("R3", 1, 2, 0, 1, 32'h1111_0004, 0, 1);
    step("R3", 1, 3, 0, 0, 32'h1111_0008, 0, 0);
    step("R3", 1, 4, 0, 1, 32'h1111_000C, 0, 1);
    // R4 + R8: data side read and write
    step("R4", 1, 1, 1, 0, 32'hA000_0010, 0, 0);
    step("R8", 1, 1, 1, 1, 32'hA000_0020, 0, 1);
    step("R4", 1, 2, 3, 0, 32'hA000_0030, 0, 0);
    step("R8", 1, 2, 4, 1, 32'hA000_0040, 0, 1);
    step("R4", 1, 3, 1, 0, 32'hA000_0050, 0, 1);
    step("R8", 1, 3, 2, 1, 32'hA000_0060, 0, 1);
    // R5 / R6: data-side direct-store errors per access type
    step("R5", 1, 4, 2, 1, 32'hB000_0002, 0, 1);
    step("R5", 1, 4, 3, 0, 32'hB000_0003, 0, 1);
    step("R5", 1, 4, 3, 1, 32'hB000_0013, 0, 1);
    step("R5", 1, 4, 4, 1, 32'hB000_0004, 0, 0);
    for (int a = 1; a < 8; a++) begin
      if (a < 2 || a > 4) step("R6", 1, 4, a, a[0], 32'hC000_0000 + a, 0, 1);
    end
    // R7: segment miss on both sides
    step("R7", 1, 5, 0, 1, 32'hD000_0000, 0, 1);
    step("R7", 1, 5, 5, 1, 32'hD000_0004, 0, 1);
    // R9: fetch fault after data fault keeps registers
    step("R9", 1, 1, 1, 1, 32'hE000_0000, 0, 0);
    step("R9", 1, 2, 0, 1, 32'hE000_0100, 0, 0);
    idle("R11", 1);
    idle("R11", 0);
    // R10: unknown outcomes ignored
    step("R10", 1, 0, 1, 1, 32'hF000_0000, 0, 1);
    step("R10", 1, 6, 2, 1, 32'hF000_0004, 0, 0);
    step("R10", 1, 7, 0, 0, 32'hF000_0008, 0, 1);
    // R2: hold, ack, fault beats ack
    idle("R2", 0);
    step("R2", 0, 0, 0, 0, 32'h0, 1, 0);
    idle("R2", 1);
    step("R2", 1, 2, 1, 1, 32'h1234_5678, 1, 1);
    step("R2", 1, 6, 1, 1, 32'h0, 1, 0);
    // R2: random overlap of fault and acknowledge
    for (int i = 0; i < 400; i++) begin
      step("R2", $urandom_range(0, 1) == 1, $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 1) == 1, $urandom, $urandom_range(0, 3) == 0,
           $urandom_range(0, 1) == 1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule